// File: doc/BRIEF.md
# Converter Serial Frame Port

This block is the serial port of a multichannel converter, built as synchronous logic on a system clock. It samples the chip-select, serial-clock and serial-data-in lines, frames each transaction of sixteen serial clocks, and shifts a 16-bit word out on SDO. That word holds a 4-bit header followed by a 12-bit conversion result taken from a converter stub. During the same frame it gathers the 16-bit command arriving on SDI and hands it to a downstream command decoder through a one-cycle strobe.

From each completed mode command the port acts on three fields only: the header-select bit, the four output-pin data bits and the power-down bit. The header carries either the current channel address or the four GPIO pin levels. GPIO inputs are latched and outputs refreshed at the start of every frame. A frame cut short by chip-select rising early is discarded.

The control state machine has three states. ST_IDLE waits with SDO released. On a chip-select fall it goes to ST_XFER ("start"). ST_XFER shifts out and captures bits. It leaves for ST_TAIL on the sixteenth serial-clock fall ("complete"), or returns to ST_IDLE on an early chip-select rise ("abort"). ST_TAIL holds SDO released and returns to ST_IDLE on the chip-select rise ("release").

Top module: `adc_serial_port`

## Requirements
- R1: After reset, sdo_oe_o, sdo_o, gpo_o, cmd_valid_o and pwr_down_o are all 0.
- R2: On the chip-select fall, SDO drives bit 15 of the output word. Each later serial-clock fall drives the next lower bit, MSB first. The header occupies bits 15..12 and the result bits 11..0, so the result MSB appears on the 4th fall.
- R3: The header is chan_addr_i by default. It is the GPIO levels latched at the chip-select fall when the most recent mode command had bit 4 set.
- R4: SDO is released (sdo_oe_o=0, sdo_o=0) from the 16th serial-clock fall until the next chip-select fall.
- R5: SDI is captured on each serial-clock rise of the frame, with the first rise giving command bit 15.
- R6: cmd_valid_o pulses for exactly one system clock after the 16th rise, with cmd_word_o holding the captured command.
- R7: gpo_o changes only at a chip-select fall, where it takes bits 3..0 of the most recent mode command. A mode command has bits 15..12 equal to 1, 2 or 3; any other command leaves the header select, output data and power-down request unchanged.
- R8: When a mode command sets bit 5, pwr_down_o rises on the 16th serial-clock fall of the next completed frame. It clears at a chip-select fall when the most recent mode command has bit 5 clear.
- R9: A chip-select rise before the 16th serial-clock rise aborts the frame: SDO is released and no cmd_valid_o pulse is given.
- R10: Line edges pass through two synchronizer stages, so an output reacting to a line edge changes on the third system clock edge after it. The serial-clock half period must be at least two system clocks.
- R11: gpi_latched_o takes the synchronized GPIO input levels at each chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idle low, asynchronous |
| sdi_i | input | 1 | Serial command data in |
| chan_addr_i | input | 4 | Current channel address from the sequencer |
| result_i | input | 12 | Conversion result from the converter stub |
| gpio_in_i | input | 4 | GPIO pin levels |
| sdo_o | output | 1 | Serial data out (0 when released) |
| sdo_oe_o | output | 1 | SDO drive enable; 0 means high impedance |
| gpo_o | output | 4 | GPIO output data |
| gpi_latched_o | output | 4 | GPIO levels latched at frame start |
| cmd_word_o | output | 16 | Last complete command word |
| cmd_valid_o | output | 1 | One-cycle strobe for cmd_word_o |
| pwr_down_o | output | 1 | Power-down request to the converter |

## Verification
Every result driven by a serial line edge appears on the third system clock edge after that edge: two synchronizer flops plus the state register. The bench therefore drives lines on a falling system clock edge and samples SDO, gpo_o, gpi_latched_o and pwr_down_o four falling edges later, before the next line change. One probe samples after two falling edges to confirm the old SDO bit is still held. The one-cycle command strobe is caught by a process that samples on every falling system clock edge, and its count is compared after each frame.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } sp_state_e;

    localparam int OPC_W = 4;

    // A mode command carries opcode 1, 2 or 3 in its top four bits.
    function automatic logic is_mode_cmd(input logic [OPC_W-1:0] opc);
        return (opc >= 4'd1) && (opc <= 4'd3);
    endfunction

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_sp_ctrl.sv
module adc_sp_ctrl
    import adc_sp_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall_i,
    input  logic cs_rise_i,
    input  logic sclk_rise_i,
    input  logic sclk_fall_i,
    output logic load_o,
    output logic shift_o,
    output logic capture_o,
    output logic word_done_o,
    output logic end_xfer_o,
    output logic oe_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    sp_state_e         state_q, state_nx;
    logic [CNT_W-1:0]  rise_cnt_q, fall_cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: start, abort, complete, release
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall_i) state_nx = ST_XFER;
            ST_XFER: begin
                if (cs_rise_i)                             state_nx = ST_IDLE;
                else if (sclk_fall_i && fall_cnt_q == LAST) state_nx = ST_TAIL;
            end
            ST_TAIL: if (cs_rise_i) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o      = 1'b0;
        shift_o     = 1'b0;
        capture_o   = 1'b0;
        word_done_o = 1'b0;
        end_xfer_o  = 1'b0;
        oe_o        = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = cs_fall_i;
            ST_XFER: begin
                oe_o = 1'b1;
                if (!cs_rise_i) begin
                    capture_o   = sclk_rise_i && (rise_cnt_q < FULL);
                    word_done_o = sclk_rise_i && (rise_cnt_q == LAST);
                    shift_o     = sclk_fall_i && (fall_cnt_q < LAST);
                    end_xfer_o  = sclk_fall_i && (fall_cnt_q == LAST);
                end
            end
            ST_TAIL: ;
            default: ;
        endcase
    end

    // edge counters for the current frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt_q <= '0;
            fall_cnt_q <= '0;
        end else if (load_o) begin
            rise_cnt_q <= '0;
            fall_cnt_q <= '0;
        end else begin
            if (capture_o)              rise_cnt_q <= rise_cnt_q + 1'b1;
            if (shift_o || end_xfer_o)  fall_cnt_q <= fall_cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_sp_shift.sv
module adc_sp_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic              shift_i,
    input  logic              oe_i,
    input  logic              capture_i,
    input  logic              word_done_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic [WORD_W-1:0] cmd_word_o,
    output logic              cmd_valid_o
);
    logic [WORD_W-1:0] tx_q, rx_q, word_q;
    logic              valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load_i) begin
            tx_q <= load_word_i;
        end else if (shift_i) begin
            tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= word_done_i;
            if (capture_i)   rx_q   <= {rx_q[WORD_W-2:0], sdi_i};
            if (word_done_i) word_q <= {rx_q[WORD_W-2:0], sdi_i};
        end
    end

    assign sdo_o       = oe_i ? tx_q[WORD_W-1] : 1'b0;
    assign cmd_word_o  = word_q;
    assign cmd_valid_o = valid_q;
endmodule

// File: rtl/adc_sp_cfg.sv
module adc_sp_cfg
    import adc_sp_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int GPIO_W  = 4,
    parameter int RD_BIT  = 4,
    parameter int PD_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [WORD_W-1:0] cmd_word_i,
    input  logic              load_i,
    input  logic              end_xfer_i,
    input  logic [GPIO_W-1:0] gpio_s_i,
    output logic              rd_en_o,
    output logic [GPIO_W-1:0] gpo_o,
    output logic [GPIO_W-1:0] gpi_o,
    output logic              pwr_down_o
);
    logic              rd_en_q, pd_req_q, pd_armed_q, pd_q;
    logic [GPIO_W-1:0] gpo_nx_q, gpo_q, gpi_q;
    logic              mode_hit;

    assign mode_hit = cmd_valid_i && is_mode_cmd(cmd_word_i[WORD_W-1 -: OPC_W]);

    // fields taken from the most recent mode command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_en_q  <= 1'b0;
            pd_req_q <= 1'b0;
            gpo_nx_q <= '0;
        end else if (mode_hit) begin
            rd_en_q  <= cmd_word_i[RD_BIT];
            pd_req_q <= cmd_word_i[PD_BIT];
            gpo_nx_q <= cmd_word_i[GPIO_W-1:0];
        end
    end

    // per-pin refresh and latch at frame start
    for (genvar p = 0; p < GPIO_W; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gpo_q[p] <= 1'b0;
                gpi_q[p] <= 1'b0;
            end else if (load_i) begin
                gpo_q[p] <= gpo_nx_q[p];
                gpi_q[p] <= gpio_s_i[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_armed_q <= 1'b0;
            pd_q       <= 1'b0;
        end else if (load_i) begin
            pd_armed_q <= pd_req_q;
            if (!pd_req_q) pd_q <= 1'b0;
        end else if (end_xfer_i && pd_armed_q) begin
            pd_q <= 1'b1;
        end
    end

    assign rd_en_o    = rd_en_q;
    assign gpo_o      = gpo_q;
    assign gpi_o      = gpi_q;
    assign pwr_down_o = pd_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
    parameter int WORD_W   = 16,
    parameter int HDR_W    = 4,
    parameter int RES_W    = 12,
    parameter int GPIO_W   = 4,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic [HDR_W-1:0]  chan_addr_i,
    input  logic [RES_W-1:0]  result_i,
    input  logic [GPIO_W-1:0] gpio_in_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [GPIO_W-1:0] gpo_o,
    output logic [GPIO_W-1:0] gpi_latched_o,
    output logic [WORD_W-1:0] cmd_word_o,
    output logic              cmd_valid_o,
    output logic              pwr_down_o
);
    localparam int LN_W = 3 + GPIO_W;

    logic [LN_W-1:0]   lines_s;
    logic              cs_s, sclk_s, sdi_s, cs_d, sclk_d;
    logic [GPIO_W-1:0] gpio_s;
    logic              cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic              load, shift, capture, word_done, end_xfer, oe, rd_en;
    logic [HDR_W-1:0]  hdr;

    adc_sp_sync #(
        .W(LN_W), .STAGES(SYNC_STG), .RST_VAL(LN_W'(1) << (LN_W - 1))
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({cs_n_i, sclk_i, sdi_i, gpio_in_i}),
        .q_o(lines_s)
    );

    assign {cs_s, sclk_s, sdi_s, gpio_s} = lines_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   =  cs_d   && !cs_s;
    assign cs_rise   = !cs_d   &&  cs_s;
    assign sclk_rise = !sclk_d &&  sclk_s;
    assign sclk_fall =  sclk_d && !sclk_s;

    adc_sp_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
        .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
        .load_o(load), .shift_o(shift), .capture_o(capture),
        .word_done_o(word_done), .end_xfer_o(end_xfer), .oe_o(oe)
    );

    assign hdr = rd_en ? HDR_W'(gpio_s) : chan_addr_i;

    adc_sp_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load_i(load), .load_word_i({hdr, result_i}),
        .shift_i(shift), .oe_i(oe),
        .capture_i(capture), .word_done_i(word_done), .sdi_i(sdi_s),
        .sdo_o(sdo_o), .cmd_word_o(cmd_word_o), .cmd_valid_o(cmd_valid_o)
    );

    adc_sp_cfg #(.WORD_W(WORD_W), .GPIO_W(GPIO_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid_o), .cmd_word_i(cmd_word_o),
        .load_i(load), .end_xfer_i(end_xfer), .gpio_s_i(gpio_s),
        .rd_en_o(rd_en), .gpo_o(gpo_o), .gpi_o(gpi_latched_o),
        .pwr_down_o(pwr_down_o)
    );

    assign sdo_oe_o = oe;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
    parameter int GPIO_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_fall,
    input logic              cs_rise,
    input logic              sclk_fall,
    input logic              sclk_rise,
    input logic              end_xfer,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic [GPIO_W-1:0] gpo_o,
    input logic              cmd_valid_o,
    input logic              pwr_down_o
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R6
    AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(sclk_rise)); // R5
    AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        end_xfer |=> !sdo_oe_o); // R4
    AST_GPO_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(gpo_o)); // R7
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_fall && !cs_rise) |=> $stable(sdo_o)); // R2
    AST_PD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down_o) |-> $past(end_xfer)); // R8
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_oe_o); // R9
endmodule

bind adc_serial_port adc_serial_port_chk #(.GPIO_W(GPIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .end_xfer(end_xfer),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .gpo_o(gpo_o),
    .cmd_valid_o(cmd_valid_o), .pwr_down_o(pwr_down_o)
);

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
    localparam int H = 4; // serial half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [3:0]  chan = '0, gpio_in = '0;
    logic [11:0] res = '0;
    logic        sdo, sdo_oe, cmd_valid, pwr_down;
    logic [3:0]  gpo, gpi_l;
    logic [15:0] cmd_word;

    int checks = 0, failures = 0;
    int valid_cnt = 0;
    logic [15:0] last_word = '0;

    // bench model of the command fields
    logic       rd_en_m = 1'b0;
    logic [3:0] gpo_nx_m = '0, gpo_m = '0;

    typedef struct { logic oe; logic d; string req; } exp_t;
    exp_t exp_q[$];
    event sample_ev;

    always #4 clk = ~clk; // 125 MHz

    adc_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .chan_addr_i(chan), .result_i(res), .gpio_in_i(gpio_in),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .gpo_o(gpo), .gpi_latched_o(gpi_l),
        .cmd_word_o(cmd_word), .cmd_valid_o(cmd_valid), .pwr_down_o(pwr_down)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic oe, input logic d, input string req);
        exp_t e;
        e.oe = oe; e.d = d; e.req = req;
        exp_q.push_back(e);
        -> sample_ev;
        #0;
    endtask

    // monitor: pops expected SDO items and compares with the port
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, {14'd0, sdo_oe, sdo}, {14'd0, e.oe, e.oe & e.d});
            end
        end
    end

    // strobe counter, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            valid_cnt <= valid_cnt + 1;
            last_word <= cmd_word;
        end
    end

    task automatic run_frame(input logic [15:0] cmd, input int nclk,
                             input logic [3:0] ch, input logic [11:0] r,
                             input logic [3:0] gp, input logic pd_start,
                             input logic pd_end, input logic probe);
        logic [15:0] w;
        int vc;
        vc = valid_cnt;
        w = {(rd_en_m ? gp : ch), r};
        gpo_m = gpo_nx_m;
        chan = ch; res = r; gpio_in = gp;
        wait_n(H);
        cs_n = 1'b0; sdi = cmd[15];
        wait_n(H);
        push(1'b1, w[15], "R2/R3 header MSB at frame start");
        check("R7 gpo refresh", {12'd0, gpo}, {12'd0, gpo_m});
        check("R11 gpi latch", {12'd0, gpi_l}, {12'd0, gp});
        check("R8 pwr_down at frame start", {15'd0, pwr_down}, {15'd0, pd_start});
        for (int k = 1; k <= nclk; k++) begin
            sclk = 1'b1;
            wait_n(H);
            sclk = 1'b0;
            sdi = (k < 16) ? cmd[15-k] : 1'b0;
            if (probe && k == 1) begin
                wait_n(2);
                check("R10 old bit held two clocks", {15'd0, sdo}, {15'd0, w[15]});
                wait_n(H - 2);
            end else begin
                wait_n(H);
            end
            if (k < 16) push(1'b1, w[15-k], (k < 4) ? "R3 header bit" : "R2 result bit");
            else        push(1'b0, 1'b0, "R4 released at 16th fall");
            if (k == 15) check("R8 pwr_down before 16th fall", {15'd0, pwr_down}, {15'd0, pd_start});
            if (k == 16) check("R8 pwr_down after 16th fall", {15'd0, pwr_down}, {15'd0, pd_end});
        end
        cs_n = 1'b1;
        wait_n(H);
        push(1'b0, 1'b0, (nclk < 16) ? "R9 abort releases SDO" : "R4 released between frames");
        if (nclk == 16) begin
            check("R6 one strobe per frame", 16'(valid_cnt), 16'(vc + 1));
            check("R5 captured command", last_word, cmd);
            if (cmd[15:12] >= 4'd1 && cmd[15:12] <= 4'd3) begin
                rd_en_m  = cmd[4];
                gpo_nx_m = cmd[3:0];
            end
        end else begin
            check("R9 no strobe on abort", 16'(valid_cnt), 16'(vc));
        end
    endtask

    initial begin
        wait_n(3);
        check("R1 reset sdo_oe", {15'd0, sdo_oe}, 16'd0);
        check("R1 reset sdo", {15'd0, sdo}, 16'd0);
        check("R1 reset gpo", {12'd0, gpo}, 16'd0);
        check("R1 reset strobe and pd", {14'd0, cmd_valid, pwr_down}, 16'd0);
        rst_n = 1'b1;
        wait_n(4);
        // mode cmd: header select on, GPO data 1001
        run_frame(16'h1019, 16, 4'h5, 12'hABC, 4'h6, 1'b0, 1'b0, 1'b1);
        // continue cmd (not a mode command): header shows GPIO, GPO now 1001
        run_frame(16'h0000, 16, 4'h2, 12'h123, 4'hA, 1'b0, 1'b0, 1'b0);
        // GPIO program opcode: ignored fields, header still GPIO (R7)
        run_frame(16'h4FFF, 16, 4'h7, 12'h800, 4'h3, 1'b0, 1'b0, 1'b0);
        // mode cmd: power-down request, header select off, GPO 0000
        run_frame(16'h2020, 16, 4'h9, 12'hFFF, 4'h6, 1'b0, 1'b0, 1'b0);
        // aborted frame after 7 clocks: no power-down, no strobe (R9)
        run_frame(16'h3000, 7, 4'hE, 12'h0F0, 4'h1, 1'b0, 1'b0, 1'b0);
        check("R7 aborted word changes nothing", {15'd0, pwr_down}, 16'd0);
        // completed frame: power-down takes effect on its 16th fall (R8)
        run_frame(16'h1000, 16, 4'hC, 12'h000, 4'h5, 1'b0, 1'b1, 1'b0);
        // mode cmd with bit 5 clear was last: pd clears at frame start
        run_frame(16'h0000, 16, 4'h1, 12'h555, 4'hF, 1'b0, 1'b0, 1'b0);
        wait_n(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule